// File: doc/BRIEF.md
# Slave-Clocked Stereo Serial Audio Output Port

This block places one pair of 24-bit audio samples onto a single serial data line once per frame. The bit clock and the frame sync both come from outside, so the block only follows the timing it is given. Two framing styles are supported. In two-channel I2S framing, channel 0 and channel 1 share a frame of 64 bit clocks. In time-division framing, the frame is built from 32-bit slots, and a 3-bit select steers the pair into slots 1-2, 3-4, 5-6 or 7-8. In every slot that carries data, the 24 data bits go out MSB first and the line is released for the remaining 8 bit periods.

A neighbouring ratio detector supplies two values: the I2S indication and the number of slots in the current frame. A converter upstream offers a new pair with a valid flag. The pair is captured once at the start of each frame, so both channels always come from the same conversion. Tristate is modelled by an output-enable. Slots that lie past the end of a short frame are never sent.

Top module: `i2s_tdm_ser`

## Requirements
- R1: While reset is asserted, and after reset until the first frame start is seen, `sdata_oe` and `sdata` are both low.
- R2: With `i2s_mode` low, a frame starts at a bit-clock rising edge where `fsync` is sampled high after being sampled low. The MSB of slot 1 is driven from the next falling edge. The falling edge of `fsync` has no effect, whatever the pulse width.
- R3: Each slot that carries data drives 24 bits MSB first, one per bit period, with each bit changing on a falling edge. `sdata_oe` is then low for the remaining 8 periods of the 32-period slot.
- R4: `fmt_sel` encoding in time-division framing: 1 selects slots 1-2, 2 selects slots 3-4, 3 selects slots 5-6, and 4 selects slots 7-8. Channel 0 goes in the lower slot and channel 1 in the upper slot. Codes 0, 5, 6 and 7 select slots 1-2.
- R5: A slot whose number (counted from 1) exceeds the `slot_count` value latched at frame start is never driven. If no new frame starts, driving stops for good once 16 slots have elapsed.
- R6: With `i2s_mode` high, a frame starts when `fsync` is sampled falling. Channel 0 occupies the 32 periods after that fall. Channel 1 starts in the period after `fsync` is sampled rising. `fmt_sel` is ignored.
- R7: The sample pair is copied into a holding register at frame start only when `smp_valid` is high. Changes to the sample inputs later in the frame do not appear in that frame. With `smp_valid` low at frame start, the previous pair is sent again.
- R8: `sdata` is low whenever `sdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Externally supplied bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge of `bclk` |
| i2s_mode | input | 1 | High selects two-channel I2S framing (from the ratio detector) |
| slot_count | input | 5 | Number of 32-bit slots in the frame (from the ratio detector) |
| fmt_sel | input | 3 | Slot-pair select, encoded as in R4 |
| smp_valid | input | 1 | New sample pair available |
| smp_ch0 | input | 24 | Channel 0 sample |
| smp_ch1 | input | 24 | Channel 1 sample |
| sdata | output | 1 | Serial data, changes on the falling edge of `bclk` |
| sdata_oe | output | 1 | High while `sdata` is actively driven |

## Verification
Two events can land in the same bit period: a frame restart, which reloads the holding register and rewinds the position counter, and the last released period of the frame before. A new sample value can also be presented on the very edge that starts a frame. The bench runs frames back to back with no idle gap between them. It alters the sample inputs a few periods into a frame, and it drops `smp_valid` on a frame start. A behavioural model is compared on every clock, so a word taken from the wrong frame, or a counter that restarts one period late, shows up as a mismatch on the first affected bit.

// File: rtl/ser_pkg.sv
package ser_pkg;
   localparam int FMT_W = 3;

   typedef enum logic [FMT_W-1:0] {
      FMT_I2S = 3'd0,
      FMT_P12 = 3'd1,
      FMT_P34 = 3'd2,
      FMT_P56 = 3'd3,
      FMT_P78 = 3'd4
   } fmt_e;
endpackage

// File: rtl/ser_frame_track.sv
module ser_frame_track
   import ser_pkg::*;
#(
   parameter int SLOT_W = 32,
   parameter int CNT_W  = 10,
   parameter int SCNT_W = 5
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              i2s_mode,
   input  logic [SCNT_W-1:0] slot_count,
   input  logic [FMT_W-1:0]  fmt_sel,
   output logic              frame_load,
   output logic [CNT_W-1:0]  pos_cnt,
   output logic              lat_mode,
   output logic [SCNT_W-1:0] lat_scnt,
   output logic [FMT_W-1:0]  lat_fmt
);
   localparam logic [CNT_W-1:0] IDLE_POS = '1;
   localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(SLOT_W);

   logic fs_q;
   logic fs_rise, fs_fall;

   assign fs_rise    = fsync & ~fs_q;
   assign fs_fall    = ~fsync & fs_q;
   assign frame_load = i2s_mode ? fs_fall : fs_rise;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q     <= 1'b0;
         pos_cnt  <= IDLE_POS;
         lat_mode <= 1'b0;
         lat_scnt <= '0;
         lat_fmt  <= FMT_I2S;
      end else begin
         fs_q <= fsync;
         if (frame_load) begin
            pos_cnt  <= '0;
            lat_mode <= i2s_mode;
            lat_scnt <= slot_count;
            lat_fmt  <= fmt_sel;
         end else if (i2s_mode && fs_rise && pos_cnt != IDLE_POS) begin
            pos_cnt <= HALF_POS;
         end else if (pos_cnt != IDLE_POS) begin
            pos_cnt <= pos_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ser_sample_hold.sv
module ser_sample_hold #(
   parameter int DATA_W = 24
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              frame_load,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_ch0,
   input  logic [DATA_W-1:0] smp_ch1,
   output logic [DATA_W-1:0] hold_ch0,
   output logic [DATA_W-1:0] hold_ch1
);
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         hold_ch0 <= '0;
         hold_ch1 <= '0;
      end else if (frame_load && smp_valid) begin
         hold_ch0 <= smp_ch0;
         hold_ch1 <= smp_ch1;
      end
   end
endmodule

// File: rtl/ser_slot_drive.sv
module ser_slot_drive
   import ser_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int SLOT_W    = 32,
   parameter int NUM_PAIRS = 4,
   parameter int CNT_W     = 10,
   parameter int SCNT_W    = 5
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  pos_cnt,
   input  logic              lat_mode,
   input  logic [SCNT_W-1:0] lat_scnt,
   input  logic [FMT_W-1:0]  lat_fmt,
   input  logic [DATA_W-1:0] hold_ch0,
   input  logic [DATA_W-1:0] hold_ch1,
   output logic              sdata,
   output logic              sdata_oe
);
   localparam int SB   = $clog2(SLOT_W);
   localparam int SI_W = CNT_W - SB;

   logic [SI_W-1:0]      slot_idx, lo_slot;
   logic [SB-1:0]        bit_idx;
   logic [NUM_PAIRS-1:0] pair_hit;
   logic [DATA_W-1:0]    word, shifted;
   logic                 is_lo, is_hi, in_frame, drive;
   int                   pair_idx, limit;

   assign slot_idx = pos_cnt[CNT_W-1:SB];
   assign bit_idx  = pos_cnt[SB-1:0];

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
      assign pair_hit[g] = (lat_fmt == FMT_W'(FMT_P12) + FMT_W'(g));
   end

   always_comb begin
      pair_idx = 0;
      for (int k = 0; k < NUM_PAIRS; k++) begin
         if (pair_hit[k]) pair_idx = k;
      end
      lo_slot  = lat_mode ? '0 : SI_W'(2 * pair_idx);
      limit    = lat_mode ? 2 : int'(lat_scnt);
      is_lo    = (slot_idx == lo_slot);
      is_hi    = (slot_idx == lo_slot + 1'b1);
      in_frame = int'(slot_idx) < limit;
      drive    = in_frame && (int'(bit_idx) < DATA_W) && (is_lo || is_hi);
      word     = is_lo ? hold_ch0 : hold_ch1;
      shifted  = word << bit_idx;
   end

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sdata    <= 1'b0;
         sdata_oe <= 1'b0;
      end else begin
         sdata_oe <= drive;
         sdata    <= drive & shifted[DATA_W-1];
      end
   end
endmodule

// File: rtl/i2s_tdm_ser.sv
module i2s_tdm_ser
   import ser_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int SLOT_W    = 32,
   parameter int MAX_SLOTS = 16,
   parameter int NUM_PAIRS = 4
) (
   input  logic                          bclk,
   input  logic                          rst_n,
   input  logic                          fsync,
   input  logic                          i2s_mode,
   input  logic [$clog2(MAX_SLOTS):0]    slot_count,
   input  logic [FMT_W-1:0]              fmt_sel,
   input  logic                          smp_valid,
   input  logic [DATA_W-1:0]             smp_ch0,
   input  logic [DATA_W-1:0]             smp_ch1,
   output logic                          sdata,
   output logic                          sdata_oe
);
   localparam int CNT_W  = $clog2(MAX_SLOTS * SLOT_W) + 1;
   localparam int SCNT_W = $clog2(MAX_SLOTS) + 1;

   if (DATA_W > SLOT_W) begin : g_bad_width
      $error("DATA_W must fit in one slot");
   end
   if ((1 << $clog2(SLOT_W)) != SLOT_W) begin : g_bad_slot
      $error("SLOT_W must be a power of two");
   end
   if (2 * NUM_PAIRS > MAX_SLOTS) begin : g_bad_pairs
      $error("slot pairs exceed the frame");
   end

   logic              frame_load, lat_mode;
   logic [CNT_W-1:0]  pos_cnt;
   logic [SCNT_W-1:0] lat_scnt;
   logic [FMT_W-1:0]  lat_fmt;
   logic [DATA_W-1:0] hold_ch0, hold_ch1;

   ser_frame_track #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .SCNT_W(SCNT_W)) u_track (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .i2s_mode(i2s_mode),
      .slot_count(slot_count), .fmt_sel(fmt_sel), .frame_load(frame_load),
      .pos_cnt(pos_cnt), .lat_mode(lat_mode), .lat_scnt(lat_scnt), .lat_fmt(lat_fmt)
   );

   ser_sample_hold #(.DATA_W(DATA_W)) u_hold (
      .bclk(bclk), .rst_n(rst_n), .frame_load(frame_load), .smp_valid(smp_valid),
      .smp_ch0(smp_ch0), .smp_ch1(smp_ch1), .hold_ch0(hold_ch0), .hold_ch1(hold_ch1)
   );

   ser_slot_drive #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .NUM_PAIRS(NUM_PAIRS),
                    .CNT_W(CNT_W), .SCNT_W(SCNT_W)) u_drive (
      .bclk(bclk), .rst_n(rst_n), .pos_cnt(pos_cnt), .lat_mode(lat_mode),
      .lat_scnt(lat_scnt), .lat_fmt(lat_fmt), .hold_ch0(hold_ch0),
      .hold_ch1(hold_ch1), .sdata(sdata), .sdata_oe(sdata_oe)
   );
endmodule

// File: rtl/i2s_tdm_ser_chk.sv
module i2s_tdm_ser_chk #(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 32
) (
   input logic bclk,
   input logic rst_n,
   input logic fsync,
   input logic sdata,
   input logic sdata_oe
);
   localparam int GAP = SLOT_W - DATA_W;

   logic fs_prev, seen;
   int   hi_run, lo_run;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         fs_prev <= 1'b0;
         seen    <= 1'b0;
         hi_run  <= 0;
         lo_run  <= GAP;
      end else begin
         fs_prev <= fsync;
         seen    <= seen | (fsync ^ fs_prev);
         hi_run  <= sdata_oe ? hi_run + 1 : 0;
         lo_run  <= sdata_oe ? 0 : ((lo_run < GAP) ? lo_run + 1 : GAP);
      end
   end

   // R8
   idle_low_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !sdata_oe |-> !sdata);

   // R3
   word_len_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      sdata_oe |-> hi_run < DATA_W);

   // R3
   slot_gap_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(sdata_oe) |-> lo_run >= GAP);

   // R1
   quiet_start_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !seen |-> !sdata_oe);
endmodule

bind i2s_tdm_ser i2s_tdm_ser_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
   .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe)
);

// File: tb/tb_i2s_tdm_ser.sv
module tb_i2s_tdm_ser;
   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic        i2s_mode = 1'b0;
   logic [4:0]  scnt = 5'd8;
   logic [2:0]  fmt = 3'd1;
   logic        smp_valid = 1'b0;
   logic [23:0] a = '0, b = '0;
   logic        sdata, sdata_oe;

   always #2 bclk = ~bclk;

   i2s_tdm_ser dut (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .i2s_mode(i2s_mode),
      .slot_count(scnt), .fmt_sel(fmt), .smp_valid(smp_valid),
      .smp_ch0(a), .smp_ch1(b), .sdata(sdata), .sdata_oe(sdata_oe)
   );

   int    n_chk = 0, n_fail = 0;
   string tag = "R1";
   bit    done = 0;

   int          m_cnt = 1023;
   bit          m_prev = 0, m_mode = 0;
   int          m_scnt = 0, m_fmt = 0;
   logic [23:0] m_h0 = '0, m_h1 = '0;

   task automatic model_step();
      bit start, rise;
      if (!rst_n) begin
         m_cnt = 1023; m_prev = 0; m_mode = 0; m_scnt = 0; m_fmt = 0;
         m_h0 = '0; m_h1 = '0;
         return;
      end
      rise  = fsync && !m_prev;
      start = i2s_mode ? (m_prev && !fsync) : rise;
      if (start) begin
         m_cnt = 0; m_mode = i2s_mode; m_scnt = int'(scnt); m_fmt = int'(fmt);
         if (smp_valid) begin m_h0 = a; m_h1 = b; end
      end else if (i2s_mode && rise && m_cnt != 1023) m_cnt = 32;
      else if (m_cnt != 1023) m_cnt++;
      m_prev = fsync;
   endtask

   task automatic compare();
      int slot, bt, lim, lo;
      bit e_oe, e_d;
      slot = m_cnt / 32; bt = m_cnt % 32;
      lim  = m_mode ? 2 : m_scnt;
      lo   = m_mode ? 0 : ((m_fmt >= 1 && m_fmt <= 4) ? 2 * (m_fmt - 1) : 0);
      e_oe = (bt < 24) && (slot < lim) && (slot == lo || slot == lo + 1);
      e_d  = e_oe ? ((slot == lo) ? m_h0[23-bt] : m_h1[23-bt]) : 1'b0;
      n_chk++;
      if (sdata_oe !== e_oe || sdata !== e_d) begin
         n_fail++;
         $display("FAIL %s t=%0t oe/data actual %b/%b expected %b/%b",
                  tag, $time, sdata_oe, sdata, e_oe, e_d);
      end
   endtask

   task automatic tick(bit fs);
      fsync = fs;
      @(posedge bclk);
      model_step();
      @(negedge bclk);
      #1;
      compare();
   endtask

   task automatic tdm_frame(int ns, int f, int pw, logic [23:0] x, logic [23:0] y,
                            bit v, bit mid);
      i2s_mode = 0; scnt = 5'(ns); fmt = 3'(f); a = x; b = y; smp_valid = v;
      for (int i = 0; i < ns * 32; i++) begin
         if (mid && i == 3) begin a = ~x; b = ~y; smp_valid = 1; end
         tick(i < pw);
      end
   endtask

   task automatic i2s_frame(int f, logic [23:0] x, logic [23:0] y, bit v);
      i2s_mode = 1; fmt = 3'(f); a = x; b = y; smp_valid = v;
      for (int i = 0; i < 64; i++) tick(i >= 32);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tag = "R1";
      for (int i = 0; i < 5; i++) tick(0);
      rst_n = 1;
      for (int i = 0; i < 10; i++) tick(0);
      tag = "R2"; tdm_frame(8, 1, 1, 24'hA5C30F, 24'h3C96E1, 1, 0);
      tag = "R3"; tdm_frame(8, 1, 1, 24'h800001, 24'h7FFFFE, 1, 0);
      tag = "R2"; tdm_frame(8, 1, 5, 24'h123456, 24'hFEDCBA, 1, 0);
      tag = "R7"; tdm_frame(8, 1, 2, 24'h0F0F0F, 24'hF0F0F0, 1, 1);
      tag = "R4"; tdm_frame(8, 2, 1, 24'hC0FFEE, 24'h5EED01, 1, 0);
      tag = "R4"; tdm_frame(8, 3, 1, 24'hBEEF12, 24'h13579B, 1, 0);
      tag = "R4"; tdm_frame(8, 4, 1, 24'h2468AC, 24'hACE024, 1, 0);
      tag = "R4"; tdm_frame(8, 0, 1, 24'h111111, 24'hEEEEEE, 1, 0);
      tag = "R4"; tdm_frame(8, 6, 1, 24'h987654, 24'h456789, 1, 0);
      tag = "R5"; tdm_frame(4, 3, 1, 24'hDEAD00, 24'h00BEEF, 1, 0);
      tag = "R5"; tdm_frame(6, 3, 1, 24'h55AA55, 24'hAA55AA, 1, 0);
      tag = "R5"; tdm_frame(6, 4, 1, 24'h777777, 24'h888888, 1, 0);
      tag = "R5"; tdm_frame(16, 4, 1, 24'h6B6B6B, 24'h949494, 1, 0);
      tag = "R6";
      i2s_mode = 1;
      for (int i = 0; i < 3; i++) tick(1);
      i2s_frame(3, 24'hF00D42, 24'h0BADC0, 1);
      i2s_frame(4, 24'h864210, 24'h013579, 1);
      i2s_frame(1, 24'hFFFFFF, 24'h000001, 1);
      tag = "R7"; i2s_frame(1, 24'h222222, 24'h333333, 0);
      tag = "R7"; tdm_frame(8, 2, 1, 24'h444444, 24'h555555, 0, 0);
      tag = "R5";
      for (int i = 0; i < 600; i++) tick(0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule